// File: doc/BRIEF.md
# Pseudo-Random Self-Test Sequencer with Serial Signature Check

This block runs a logic self-test on a 16-bit combinational datapath that it instantiates. On a start request it clears a pattern generator and a signature register, then applies a programmed number of pseudo-random vectors to the datapath. The signature register folds every datapath response into itself. When the run ends, the block shifts the signature out on one pin, most significant bit first. While it shifts, it compares each bit with a golden value that is held on an input.

When the comparison finishes, `done` rises. `pass` then tells whether all 16 bits matched. A new start can be issued from the finished state to run again with another count. The golden value comes from a model outside the block. A mismatch means the datapath, or the test logic itself, is faulty.

Top module: `lfsr_misr_bist`

## Requirements
- R1: After reset, `done`, `pass`, `ser_vld` and `sig_out` are all 0, and the block waits for `start`.
- R2: The pattern generator is loaded with all zeros at the start of every test. On each run cycle it shifts left by one bit. Its new bit 0 is the inverted parity of the bits selected by `TAPS`, which by default are bits 15, 13, 12 and 10. This XNOR feedback keeps the all-zeros state inside the sequence, so the generator never reaches all ones.
- R3: The datapath under test computes `y = x + {x[7:0], x[15:8]}` modulo 2^16, where `x` is the generator state.
- R4: The signature register is cleared at the start of every test. On each run cycle it becomes `{s[14:0], ^(s & TAPS)} ^ y`.
- R5: The run phase applies exactly `vec_cnt` vectors, where `vec_cnt` is sampled when `start` is accepted. A count of 0 skips the run phase, which leaves the signature at zero.
- R6: The shift phase lasts 16 cycles, and `ser_vld` is high throughout it. In shift cycle k, `sig_out` carries signature bit 15-k.
- R7: `done` rises on rising edge `vec_cnt`+18, counting the edge that accepts `start` as edge 1. It stays high until the next accepted start.
- R8: `pass` is 1 exactly when every shifted bit equals `exp_sig`, whose bit 15 is compared first. `exp_sig` must be held stable through the shift phase.
- R9: `pass` is 0 whenever `done` is 0. Accepting a new `start` clears both `done` and `pass` on that edge.
- R10: `start` is ignored while a test is in progress. A pulse during the run leaves both the timing and the signature of that test unchanged.
- R11: A count of 65535 is accepted, which applies the generator's full exhaustive sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Test request, accepted when idle or finished |
| vec_cnt | input | 17 | Number of vectors to apply |
| exp_sig | input | 16 | Golden signature |
| sig_out | output | 1 | Serial signature bit, most significant bit first |
| ser_vld | output | 1 | High while `sig_out` carries signature bits |
| done | output | 1 | Test finished |
| pass | output | 1 | Signature matched the golden value, valid while `done` is high |

## Verification
The bench builds the block with its default parameters: 16-bit width, default feedback taps, the swap-add datapath and a 17-bit count. A 17-bit count reaches 65535 vectors, so one run covers the full exhaustive sequence. Each test in the table runs its count for real, and the bench checks both the latency and the serially captured signature. Corrupting single golden bits, including the first and last bits shifted out, checks that the comparison covers every bit position.

// File: rtl/bist_pkg.sv
package bist_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_INIT  = 3'd1,
      ST_RUN   = 3'd2,
      ST_SHIFT = 3'd3,
      ST_DONE  = 3'd4
   } bist_state_e;

   typedef enum logic [1:0] {
      SR_HOLD    = 2'b00,
      SR_COMPACT = 2'b01,
      SR_SHIFT   = 2'b10
   } sr_mode_e;
endpackage

// File: rtl/bist_patgen.sv
module bist_patgen #(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] pat
);
   logic [W-1:0] q;
   logic         fb;

   assign fb  = ~(^(q & TAPS));
   assign pat = q;

   always_ff @(posedge clk) begin
      if (rst || clr) q <= '0;
      else if (step)  q <= {q[W-2:0], fb};
   end

   // R2: cleared generator starts at zero
   a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
      clr |=> (q == '0));
   // R2: XNOR sequence from zero never reaches the lock-up state
   a_r2_no_lockup: assert property (@(posedge clk) disable iff (rst)
      q != '1);
   // R2: generator holds when not stepped
   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      (!clr && !step) |=> $stable(q));
endmodule

// File: rtl/bist_cut.sv
module bist_cut #(
   parameter int unsigned W       = 16,
   parameter int unsigned CUT_SEL = 0
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);
   localparam int unsigned H = W / 2;

   generate
      if (CUT_SEL == 0) begin : g_swap_add
         assign y = x + {x[H-1:0], x[W-1:H]};
      end else begin : g_xor_rot
         assign y = x ^ {x[W-2:0], x[W-1]};
      end
   endgenerate
endmodule

// File: rtl/bist_misr.sv
module bist_misr
   import bist_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  sr_mode_e     mode,
   input  logic [W-1:0] din,
   output logic [W-1:0] sig
);
   logic [W-1:0] s;
   logic         fb;

   assign fb  = ^(s & TAPS);
   assign sig = s;

   always_ff @(posedge clk) begin
      if (rst || clr) s <= '0;
      else begin
         unique case (mode)
            SR_COMPACT: s <= {s[W-2:0], fb} ^ din;
            SR_SHIFT:   s <= {s[W-2:0], 1'b0};
            default:    s <= s;
         endcase
      end
   end

   // R4: hold mode keeps the signature
   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (!clr && mode == SR_HOLD) |=> $stable(s));
   // R6: shift mode moves bits toward the serial end and fills with zero
   a_r6_shift_move: assert property (@(posedge clk) disable iff (rst)
      (!clr && mode == SR_SHIFT) |=> (s[W-1:1] == $past(s[W-2:0]) && !s[0]));
   // R4: cleared signature is zero
   a_r4_clear: assert property (@(posedge clk) disable iff (rst)
      clr |=> (s == '0));
endmodule

// File: rtl/bist_seq.sv
module bist_seq
   import bist_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] vec_cnt,
   input  logic [W-1:0]     exp_sig,
   input  logic             sig_msb,
   output logic             pg_clr,
   output logic             pg_step,
   output logic             sr_clr,
   output sr_mode_e         sr_mode,
   output logic             ser_vld,
   output logic             done,
   output logic             pass
);
   localparam int unsigned BC_W = $clog2(W);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(W - 1);

   bist_state_e      st_q;
   logic [CNT_W-1:0] n_q;
   logic [CNT_W-1:0] run_q;
   logic [BC_W-1:0]  bit_q;
   logic [BC_W-1:0]  idx;
   logic             mis_q, done_q, pass_q, bit_bad;

   assign idx     = LAST_BIT - bit_q;
   assign bit_bad = sig_msb ^ exp_sig[idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         n_q    <= '0;
         run_q  <= '0;
         bit_q  <= '0;
         mis_q  <= 1'b0;
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  st_q   <= ST_INIT;
                  n_q    <= vec_cnt;
                  mis_q  <= 1'b0;
                  done_q <= 1'b0;
                  pass_q <= 1'b0;
               end
            end
            ST_INIT: begin
               run_q <= '0;
               bit_q <= '0;
               st_q  <= (n_q == '0) ? ST_SHIFT : ST_RUN;
            end
            ST_RUN: begin
               if (run_q == n_q - 1'b1) st_q <= ST_SHIFT;
               else                     run_q <= run_q + 1'b1;
            end
            ST_SHIFT: begin
               mis_q <= mis_q | bit_bad;
               bit_q <= bit_q + 1'b1;
               if (bit_q == LAST_BIT) begin
                  st_q   <= ST_DONE;
                  done_q <= 1'b1;
                  pass_q <= ~(mis_q | bit_bad);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      pg_clr  = (st_q == ST_INIT);
      sr_clr  = (st_q == ST_INIT);
      pg_step = (st_q == ST_RUN);
      ser_vld = (st_q == ST_SHIFT);
      if (st_q == ST_RUN)        sr_mode = SR_COMPACT;
      else if (st_q == ST_SHIFT) sr_mode = SR_SHIFT;
      else                       sr_mode = SR_HOLD;
   end

   assign done = done_q;
   assign pass = pass_q;

   // R9: pass only valid alongside done
   a_r9_pass_needs_done: assert property (@(posedge clk) disable iff (rst)
      pass_q |-> done_q);
   // R7: done persists until a new start
   a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
      (done_q && !start) |=> done_q);
   // R10: start during a run does not restart the test
   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_RUN && start && run_q != n_q - 1'b1) |=> (st_q == ST_RUN));
   // R5: empty run goes straight to unload
   a_r5_zero_skip: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_INIT && n_q == '0) |=> (st_q == ST_SHIFT && bit_q == '0));
   // R9: accepted start clears done and pass
   a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
      ((st_q == ST_IDLE || st_q == ST_DONE) && start) |=> (!done_q && !pass_q));
endmodule

// File: rtl/lfsr_misr_bist.sv
module lfsr_misr_bist
   import bist_pkg::*;
#(
   parameter int unsigned W       = 16,
   parameter int unsigned CNT_W   = 17,
   parameter logic [W-1:0] TAPS    = 16'hB400,
   parameter int unsigned CUT_SEL = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] vec_cnt,
   input  logic [W-1:0]     exp_sig,
   output logic             sig_out,
   output logic             ser_vld,
   output logic             done,
   output logic             pass
);
   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_width
         $error("W must be even and at least 4");
      end
      if (!TAPS[W-1]) begin : g_bad_taps
         $error("TAPS must include the top bit");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [W-1:0] pat, resp, sig;
   logic         pg_clr, pg_step, sr_clr;
   sr_mode_e     sr_mode;

   bist_seq #(.W(W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst(rst), .start(start), .vec_cnt(vec_cnt),
      .exp_sig(exp_sig), .sig_msb(sig[W-1]),
      .pg_clr(pg_clr), .pg_step(pg_step), .sr_clr(sr_clr),
      .sr_mode(sr_mode), .ser_vld(ser_vld), .done(done), .pass(pass)
   );

   bist_patgen #(.W(W), .TAPS(TAPS)) u_pat (
      .clk(clk), .rst(rst), .clr(pg_clr), .step(pg_step), .pat(pat)
   );

   bist_cut #(.W(W), .CUT_SEL(CUT_SEL)) u_cut (
      .x(pat), .y(resp)
   );

   bist_misr #(.W(W), .TAPS(TAPS)) u_misr (
      .clk(clk), .rst(rst), .clr(sr_clr), .mode(sr_mode),
      .din(resp), .sig(sig)
   );

   assign sig_out = ser_vld & sig[W-1];

   // R6: serial bit is quiet outside the unload window
   a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
      !ser_vld |-> !sig_out);
   // R6: unload and done never overlap
   a_r6_vld_not_done: assert property (@(posedge clk) disable iff (rst)
      ser_vld |-> !done);
endmodule

// File: tb/lfsr_misr_bist_test.sv
module lfsr_misr_bist_test;
   localparam int PERIOD = 10;
   localparam logic [15:0] TAPS = 16'hB400;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [16:0] vec_cnt = '0;
   logic [15:0] exp_sig = '0;
   logic        sig_out, ser_vld, done, pass;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #(PERIOD/2) clk = ~clk;

   lfsr_misr_bist uut (
      .clk(clk), .rst(rst), .start(start), .vec_cnt(vec_cnt),
      .exp_sig(exp_sig), .sig_out(sig_out), .ser_vld(ser_vld),
      .done(done), .pass(pass)
   );

   // entry: [32:16] vector count, [15:0] bits flipped in the golden value
   localparam logic [32:0] TBL [8] = '{
      {17'd1,    16'h0000},
      {17'd2,    16'h0000},
      {17'd5,    16'h0000},
      {17'd16,   16'h0000},
      {17'd100,  16'h0000},
      {17'd1000, 16'h0000},
      {17'd37,   16'h8000},
      {17'd37,   16'h0001}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", tag, act, expv);
      end
   endtask

   function automatic logic [15:0] model_sig(input int n);
      logic [15:0] l = '0;
      logic [15:0] m = '0;
      logic [15:0] y;
      for (int i = 0; i < n; i++) begin
         y = l + {l[7:0], l[15:8]};
         m = {m[14:0], ^(m & TAPS)} ^ y;
         l = {l[14:0], ~(^(l & TAPS))};
      end
      return m;
   endfunction

   // runs one test; poke>0 pulses start at that edge number
   task automatic run_one(input int n, input logic [15:0] golden, input int poke,
                          output int edges, output logic [15:0] cap,
                          output int nbits);
      vec_cnt = n[16:0];
      exp_sig = golden;
      start   = 1'b1;
      @(posedge clk);
      edges = 1;
      cap   = '0;
      nbits = 0;
      @(negedge clk);
      start = 1'b0;
      chk(!done && !pass, "R9 start clears done/pass", {done, pass}, 0);
      forever begin
         @(posedge clk);
         edges++;
         @(negedge clk);
         start = (edges == poke);
         if (ser_vld) begin
            cap = {cap[14:0], sig_out};
            nbits++;
         end
         if (done || edges > n + 100) break;
      end
      start = 1'b0;
   endtask

   initial begin
      int          edges, nbits;
      logic [15:0] cap, g;
      repeat (3) @(negedge clk);
      chk(!done && !pass && !ser_vld && !sig_out, "R1 reset outputs",
          {done, pass, ser_vld, sig_out}, 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk(!done && !ser_vld, "R1 idle without start", {done, ser_vld}, 0);

      foreach (TBL[i]) begin
         int n;
         logic [15:0] flip;
         n    = int'(TBL[i][32:16]);
         flip = TBL[i][15:0];
         g    = model_sig(n);
         run_one(n, g ^ flip, 0, edges, cap, nbits);
         chk(edges == n + 18, "R5 R7 latency", edges, n + 18);
         chk(nbits == 16, "R6 shift length", nbits, 16);
         chk(cap == g, "R2 R3 R4 R6 signature", cap, g);
         chk(done && pass == (flip == 0), "R8 compare", pass, flip == 0);
      end

      // R9: pass remains until restart, then is cleared
      g = model_sig(3);
      run_one(3, g, 0, edges, cap, nbits);
      repeat (4) @(negedge clk);
      chk(done && pass, "R7 R9 result held", {done, pass}, 3);

      // R5: empty run, signature zero
      run_one(0, 16'h0000, 0, edges, cap, nbits);
      chk(edges == 18, "R5 zero count latency", edges, 18);
      chk(cap == 16'h0000 && pass, "R5 zero count signature", cap, 0);

      // R10: start pulse during run is ignored
      g = model_sig(50);
      run_one(50, g, 20, edges, cap, nbits);
      chk(edges == 68, "R10 busy start timing", edges, 68);
      chk(cap == g && pass, "R10 busy start signature", cap, g);
      repeat (3) @(negedge clk);
      chk(done, "R10 no restart after run", done, 1);

      // R11: exhaustive sequence
      g = model_sig(65535);
      run_one(65535, g, 0, edges, cap, nbits);
      chk(edges == 65535 + 18, "R11 exhaustive latency", edges, 65553);
      chk(cap == g && pass, "R11 exhaustive signature", cap, g);

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 190000);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule